// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the bus side of a serial byte memory that sits on a two-wire clock/data bus. The clock and data lines are oversampled by the system clock. Start and Stop conditions are found from the sampled levels. A device select byte is checked against a fixed four-bit type code and three strap inputs. The memory then takes a two-byte address into its internal address counter. It serves single-byte writes and three kinds of read: current-address, random-address and sequential.

The data line is modelled as two separate signals. One is an input that carries the resolved bus level. The other is an output enable, which pulls the line low when set. After a byte write is closed by a Stop, the block runs an internal write cycle whose length is set by a parameter in system clocks. During that cycle it refuses its own select byte, so a master can poll until the cycle ends. A write-lock input blocks writes and leaves reads unaffected.

Top module: `tws_mem_slave`

## Requirements
- R1: After reset the data output enable `sda_oe` is low, and it stays low until a select byte is matched.
- R2: The select byte is sent MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `chip_sel`. Bit 0 gives the direction: 0 is write, 1 is read. On a match the block acknowledges by driving the line low during the 9th clock. On a mismatch it releases the line and ignores the bus until the next Start.
- R3: A Stop that follows an acknowledged data byte starts a write cycle of `WCYC_CLKS` system clocks. During that cycle a matching select byte is not acknowledged. Once the cycle ends, the select byte is acknowledged again.
- R4: A write is a write-direction select, an address high byte, an address low byte and one data byte, each acknowledged. The data byte is stored at the address when the closing Stop is seen. The counter then points one past that address. Further data bytes before the Stop are not acknowledged.
- R5: A random read is a write-direction select and two address bytes, then a repeated Start and a read-direction select. It returns the byte at that address. A repeated select whose bits 7..1 differ is not acknowledged.
- R6: A current-address read, which is a read-direction select straight after Start, returns the byte at the address counter. The counter then advances by one.
- R7: When the master acknowledges a read byte, the next byte comes from the following address. After address 2^ADDR_W-1 the counter wraps to 0.
- R8: The address is sent most significant byte first. Only its low ADDR_W bits select the byte, and the higher bits are ignored.
- R9: When the master does not pull the line low in the 9th clock after a read byte, the block stops driving. It leaves the line released for any further clocks until a Start.
- R10: While `wr_lock` is high a data byte is not acknowledged, the memory keeps its old value, and no write cycle begins. Reads work whatever the level of `wr_lock`.
- R11: A Start or Stop at any bit position aborts the current transfer and resets the bit count. A Stop before a complete data byte starts no write cycle and stores nothing.
- R12: `sda_oe` is raised only while the sampled clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 3 | Strap value that select bits 3..1 must equal |
| wr_lock | input | 1 | When high, data bytes are refused and the memory is not written |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Resolved bus data line level |
| sda_oe | output | 1 | When high, the block pulls the data line low |

## Verification
The bench builds the block with ADDR_W = 4, so the array holds 16 bytes. This lets a short sequential read cross from the last address back to zero. It also means that high address bits set by the master are plainly ignored. WCYC_CLKS = 500 is long enough for the first poll after a write to land inside the write cycle and be refused, and short enough for the second poll to be accepted. A bit period of 32 system clocks leaves room for the input synchronisers between each bus edge and the block's reaction.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_HOLD
    } tws_state_e;

    typedef enum logic [1:0] {
        BY_SEL,
        BY_AHI,
        BY_ALO,
        BY_DATA
    } tws_byte_e;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int SW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SW-1:0] scl_sh;
        logic [SW-1:0] sda_sh;
    } sync_t;

    sync_t d, q;

    logic scl_prev, sda_prev;

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[SW-2:0], scl_in};
        d.sda_sh = {q.sda_sh[SW-2:0], sda_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_lvl  = q.scl_sh[SW-2];
    assign sda_lvl  = q.sda_sh[SW-2];
    assign scl_prev = q.scl_sh[SW-1];
    assign sda_prev = q.sda_sh[SW-1];

    assign scl_rise = scl_lvl & ~scl_prev;
    assign scl_fall = ~scl_lvl & scl_prev;
    assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/tws_byte_array.sv
module tws_byte_array #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tws_wcycle_timer.sv
module tws_wcycle_timer #(
    parameter int WCYC_CLKS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(WCYC_CLKS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(WCYC_CLKS);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

    // R3
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WCYC_CLKS));

endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
    import tws_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int WCYC_CLKS   = 100000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] chip_sel,
    input  logic       wr_lock,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe
);
    localparam int AW = ADDR_W;

    typedef struct packed {
        tws_state_e    st;
        tws_byte_e     kind;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic          rd_mode;
        logic [7:0]    ahi;
        logic [AW-1:0] ptr;
        logic          oe;
        logic          mack;
        logic          wpend;
        logic [7:0]    wdat;
        logic [AW-1:0] waddr;
    } eng_t;

    eng_t d, q;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic wcyc_busy, wcyc_go, mem_we;
    logic [7:0] rdata;
    logic sel_hit;

    tws_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    tws_byte_array #(.ADDR_W(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (q.waddr),
        .wdata (q.wdat),
        .raddr (q.ptr),
        .rdata (rdata)
    );

    tws_wcycle_timer #(.WCYC_CLKS(WCYC_CLKS)) u_wcyc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wcyc_go),
        .busy  (wcyc_busy)
    );

    assign sel_hit = (q.sh[7:1] == {DEV_TYPE_CODE, chip_sel});

    always_comb begin
        d       = q;
        mem_we  = 1'b0;
        wcyc_go = 1'b0;

        if (stop_ev) begin
            if (q.wpend) begin
                mem_we  = 1'b1;
                wcyc_go = 1'b1;
                d.ptr   = q.waddr + 1'b1;
            end
            d.st    = ST_IDLE;
            d.oe    = 1'b0;
            d.wpend = 1'b0;
            d.cnt   = '0;
        end else if (start_ev) begin
            d.st    = ST_RX;
            d.kind  = BY_SEL;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.wpend = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.st = ST_IDLE;
                        unique case (q.kind)
                            BY_SEL: begin
                                if (sel_hit && !wcyc_busy) begin
                                    d.st      = ST_ACK;
                                    d.oe      = 1'b1;
                                    d.rd_mode = q.sh[0];
                                end
                            end
                            BY_AHI: begin
                                d.ahi = q.sh;
                                d.st  = ST_ACK;
                                d.oe  = 1'b1;
                            end
                            BY_ALO: begin
                                d.ptr = AW'({q.ahi, q.sh});
                                d.st  = ST_ACK;
                                d.oe  = 1'b1;
                            end
                            BY_DATA: begin
                                if (!wr_lock) begin
                                    d.wdat  = q.sh;
                                    d.waddr = q.ptr;
                                    d.wpend = 1'b1;
                                    d.st    = ST_ACK;
                                    d.oe    = 1'b1;
                                end
                            end
                            default: d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        unique case (q.kind)
                            BY_SEL: begin
                                if (q.rd_mode) begin
                                    d.sh  = {rdata[6:0], 1'b0};
                                    d.oe  = ~rdata[7];
                                    d.ptr = q.ptr + 1'b1;
                                    d.cnt = 4'd1;
                                    d.st  = ST_TX;
                                end else begin
                                    d.kind = BY_AHI;
                                    d.st   = ST_RX;
                                end
                            end
                            BY_AHI: begin
                                d.kind = BY_ALO;
                                d.st   = ST_RX;
                            end
                            BY_ALO: begin
                                d.kind = BY_DATA;
                                d.st   = ST_RX;
                            end
                            default: d.st = ST_HOLD;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt < 4'd8) begin
                            d.oe  = ~q.sh[7];
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.cnt = q.cnt + 1'b1;
                        end else begin
                            d.oe   = 1'b0;
                            d.mack = 1'b0;
                            d.st   = ST_RACK;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.mack = 1'b1;
                        end
                    end else if (scl_fall && q.mack) begin
                        d.sh   = {rdata[6:0], 1'b0};
                        d.oe   = ~rdata[7];
                        d.ptr  = q.ptr + 1'b1;
                        d.cnt  = 4'd1;
                        d.mack = 1'b0;
                        d.st   = ST_TX;
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

    // R12
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_lvl);

    // R3
    no_sel_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK && q.kind == BY_SEL) |-> !wcyc_busy);

    // R7
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TX && $past(q.st) != ST_TX) |-> (q.ptr == AW'($past(q.ptr) + 1'b1)));

    // R9
    release_on_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_RACK && q.st == ST_IDLE) |-> !q.oe);

endmodule

// File: tb/tb_tws_mem_slave.sv
module tb_tws_mem_slave;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int WCYC  = 500;
    localparam int Q     = 8;
    localparam logic [2:0] CS = 3'b101;
    localparam logic [7:0] SEL_W = {4'b1010, CS, 1'b0};
    localparam logic [7:0] SEL_R = {4'b1010, CS, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wr_lock = 1'b0;
    logic sda_oe;
    logic sda_line;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    tws_mem_slave #(.ADDR_W(AW), .WCYC_CLKS(WCYC)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_sel (CS),
        .wr_lock  (wr_lock),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int hi_rise_viol = 0;
    logic [7:0] model [DEPTH];
    int cur_ptr = 0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {24'd0, g}, {24'd0, e});
            end
        end
    end

    // R12 monitor: drive must not start while the clock line is high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_prev && scl_m) hi_rise_viol++;
        oe_prev <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = ~sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl_m = 1'b0;
        end
        sda_m = ~mack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_byte(input logic [15:0] a, input logic [7:0] v, input bit poll_chk);
        logic ak;
        int polls;
        bus_start;
        send_byte(SEL_W, ak);  chk("R2 write select ack", ak, 1);
        send_byte(a[15:8], ak); chk("R4 addr high ack", ak, 1);
        send_byte(a[7:0], ak);  chk("R4 addr low ack", ak, 1);
        send_byte(v, ak);       chk("R4 data ack", ak, 1);
        bus_stop;
        model[a[AW-1:0]] = v;
        cur_ptr = (int'(a[AW-1:0]) + 1) % DEPTH;
        polls = 0;
        ak = 1'b0;
        while (!ak) begin
            bus_start;
            send_byte(SEL_W, ak);
            bus_stop;
            if (polls == 0 && poll_chk) chk("R3 select refused during write cycle", ak, 0);
            polls++;
        end
        if (poll_chk) chk("R3 select accepted after write cycle", polls > 1, 1);
    endtask

    task automatic set_addr(input logic [15:0] a);
        logic ak;
        bus_start;
        send_byte(SEL_W, ak);   chk("R5 dummy write select ack", ak, 1);
        send_byte(a[15:8], ak); chk("R8 addr high ack", ak, 1);
        send_byte(a[7:0], ak);  chk("R8 addr low ack", ak, 1);
    endtask

    task automatic rnd_read(input logic [15:0] a, input int n, input string tag);
        logic ak;
        logic [7:0] b;
        set_addr(a);
        bus_start;
        send_byte(SEL_R, ak); chk("R5 repeated read select ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(model[(int'(a[AW-1:0]) + k) % DEPTH]);
            tag_q.push_back(tag);
            recv_byte(k < n - 1, b);
            got_q.push_back(b);
        end
        cur_ptr = (int'(a[AW-1:0]) + n) % DEPTH;
        bus_stop;
    endtask

    task automatic cur_read(input string tag);
        logic ak;
        logic [7:0] b;
        bus_start;
        send_byte(SEL_R, ak); chk("R6 current read select ack", ak, 1);
        exp_q.push_back(model[cur_ptr]);
        tag_q.push_back(tag);
        recv_byte(1'b0, b);
        got_q.push_back(b);
        cur_ptr = (cur_ptr + 1) % DEPTH;
        bus_stop;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // watchdog
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary;
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] b;
        int seen;

        tick(10);
        rst_n = 1'b1;
        tick(4);
        // R1
        chk("R1 output enable low after reset", sda_oe, 0);

        // R2: wrong strap bits
        bus_start;
        send_byte({4'b1010, 3'b011, 1'b0}, ak);
        chk("R2 mismatched select not acked", ak, 0);
        bus_stop;
        chk("R1 output enable still low", sda_oe, 0);
        // R2: wrong type nibble
        bus_start;
        send_byte({4'b1011, CS, 1'b1}, ak);
        chk("R2 wrong type code not acked", ak, 0);
        bus_stop;

        // R4 / R3: fill the array
        for (int i = 0; i < DEPTH; i++) begin
            write_byte(16'(i), 8'(8'h30 + 8'(i * 7)), i == 0);
        end

        // R4: a second data byte before Stop is refused
        bus_start;
        send_byte(SEL_W, ak);
        send_byte(8'h00, ak);
        send_byte(8'h0C, ak);
        send_byte(8'hA5, ak); chk("R4 single data byte ack", ak, 1);
        send_byte(8'h11, ak); chk("R4 extra data byte refused", ak, 0);
        bus_stop;
        model[12] = 8'hA5;
        ak = 1'b0;
        while (!ak) begin
            bus_start; send_byte(SEL_W, ak); bus_stop;
        end

        // R5: random read
        rnd_read(16'h0005, 1, "R5 random read data");
        // R6: current read
        cur_read("R6 current read next address");
        cur_read("R6 current read advances again");
        // R7: sequential read across the wrap
        rnd_read(16'h000E, 5, "R7 sequential read with wrap");
        cur_read("R7 counter after wrapped burst");
        // R8: upper address bits ignored
        rnd_read(16'h1239, 1, "R8 high address bits ignored");
        rnd_read(16'hFF0C, 2, "R8 and R4 stored byte and neighbour");

        // R5: repeated select with different strap bits
        set_addr(16'h0004);
        bus_start;
        send_byte({4'b1010, 3'b011, 1'b1}, ak);
        chk("R5 differing repeated select refused", ak, 0);
        bus_stop;

        // R9: master nak then extra clocks
        set_addr(16'h0003);
        bus_start;
        send_byte(SEL_R, ak);
        exp_q.push_back(model[3]);
        tag_q.push_back("R9 byte before master nak");
        recv_byte(1'b0, b);
        got_q.push_back(b);
        seen = 0;
        for (int i = 0; i < 9; i++) begin
            tick(Q); scl_m = 1'b1; tick(Q);
            if (sda_line !== 1'b1 || sda_oe !== 1'b0) seen++;
            tick(Q); scl_m = 1'b0;
        end
        tick(Q);
        chk("R9 line released after master nak", seen, 0);
        bus_stop;
        cur_ptr = 4;

        // R10: write lock
        wr_lock = 1'b1;
        bus_start;
        send_byte(SEL_W, ak);  chk("R10 select acked under lock", ak, 1);
        send_byte(8'h00, ak);
        send_byte(8'h02, ak);
        send_byte(8'hEE, ak);  chk("R10 data refused under lock", ak, 0);
        bus_stop;
        bus_start;
        send_byte(SEL_W, ak);  chk("R10 no write cycle under lock", ak, 1);
        bus_stop;
        rnd_read(16'h0002, 1, "R10 memory unchanged, read under lock");
        wr_lock = 1'b0;

        // R11: Stop in the middle of a data byte
        bus_start;
        send_byte(SEL_W, ak);
        send_byte(8'h00, ak);
        send_byte(8'h08, ak);
        send_bits(8'hC3, 4);
        bus_stop;
        bus_start;
        send_byte(SEL_W, ak);  chk("R11 aborted write starts no cycle", ak, 1);
        bus_stop;
        rnd_read(16'h0008, 1, "R11 aborted write stored nothing");

        // R11: Start in the middle of a select byte
        bus_start;
        send_bits(SEL_W, 4);
        rnd_read(16'h0007, 1, "R11 restart after partial byte");

        tick(4 * Q);
        chk("R12 no drive raised while clock high", hi_rise_viol, 0);
        chk("R2 all expected bytes observed", exp_q.size(), 0);

        done = 1'b1;
        summary;
        $finish;
    end

endmodule